// File: doc/BRIEF.md
# Rounding Widening Fixed-Point Multiplier

This block multiplies signed two's-complement fixed-point operands and returns a result twice as wide as an operand. A shared runtime input, the fraction count, says how many bits of every operand lie below the binary point. The full product carries twice that many fraction bits. The block shifts the product right by the fraction count so that the result has the same binary-point position as the operands. The bits shifted out are rounded to the nearest value, and an exact half goes to the even neighbour. Because the result is twice the operand width, the operation cannot overflow.

Alongside each result the block reports three flags: zero, negative and inexact. Carry and overflow outputs are present and always read 0. Operations enter through a valid-qualified input and leave through a valid-qualified output after a fixed latency. The latency is 3 cycles for operand widths up to 32 bits and 4 cycles for wider operands. One operation may enter every cycle, and there is no back-pressure. A lane parameter replicates the datapath into a vector form. All lanes share the fraction count and have the same latency as the scalar form.

Top module: `fxmul_round_wide`

## Requirements
- R1: For each lane, when the fraction count d lies in 0..W-1, the result equals the signed product of the lane operands divided by 2^d and rounded to the nearest integer. The result is 2W bits wide in two's complement.
- R2: When the discarded part of the product is exactly one half of a result unit, the result is the nearer even value: its least significant bit is 0. This holds for both positive and negative products.
- R3: When the fraction count is 0, the result is the exact full product and the inexact flag is 0.
- R4: A fraction-count input greater than W-1 is treated as W-1.
- R5: The zero flag of a lane (`out_zero[i]`) is 1 exactly when that lane's 2W-bit result is 0.
- R6: The negative flag of a lane (`out_neg[i]`) equals bit 2W-1 of that lane's result.
- R7: The inexact flag of a lane (`out_inexact[i]`) is 1 exactly when at least one bit discarded by the shift was non-zero.
- R8: `out_carry` and `out_ovf` are 0 for every lane whenever `out_valid` is 1.
- R9: `out_valid` is 1 exactly L clock edges after an edge that sampled `in_valid` as 1. L is 3 when W is 32 or less and 4 when W is greater than 32. An operation may be accepted on every edge, and results come out in the order the operations entered.
- R10: Lane i takes its operands from bits [i*W +: W] of `in_a` and `in_b` and returns its result in bits [i*2W +: 2W] of `out_res`. Lanes do not affect one another.
- R11: While `rst_n` is 0 at a clock edge, `out_valid` is 0 after that edge and `out_res` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| in_a | input | LANES*W | First operand, one W-bit field per lane |
| in_b | input | LANES*W | Second operand, one W-bit field per lane |
| in_dot | input | $clog2(W)+1 | Fraction-bit count shared by all lanes; values above W-1 are treated as W-1 |
| out_valid | output | 1 | Result present on the outputs |
| out_res | output | LANES*2*W | Rounded result, one 2W-bit field per lane |
| out_zero | output | LANES | Per-lane zero flag |
| out_neg | output | LANES | Per-lane negative flag |
| out_inexact | output | LANES | Per-lane inexact flag |
| out_carry | output | LANES | Per-lane carry flag, always 0 |
| out_ovf | output | LANES | Per-lane overflow flag, always 0 |

## Verification
The bench builds two copies of the block. The first uses W=16 with two lanes. It exercises the 3-cycle latency, lane independence, and clamping of the 5-bit fraction-count input, whose values 16..31 are all out of range. The second uses W=40 with one lane. It brings the 4-cycle variant within reach, along with 80-bit products and a 7-bit fraction count. Each copy is driven with a fixed-seed random stream that has gaps in the valid input. Directed cases are mixed in: ties of both signs, the most negative operand squared, zero products and clamped counts.

// File: rtl/fxm_pkg.sv
// Shared definitions for the rounding widening fixed-point multiplier.
// Assumes: latency depends only on the operand width.
package fxm_pkg;

    // Pipeline depth from operand width: narrow sizes take 3 stages, wide take 4.
    function automatic int fxm_latency(input int w);
        return (w > 32) ? 4 : 3;
    endfunction

endpackage

// File: rtl/fxm_round.sv
// Combinational realignment of a full product: arithmetic right shift by the
// fraction count, then round to nearest with ties to even, plus flags.
// Assumes: dot is already clamped to 0..W-1, so the increment cannot wrap.
module fxm_round #(
    parameter int PW  = 32,
    parameter int SHW = 4
) (
    input  logic [PW-1:0]  prod,
    input  logic [SHW-1:0] dot,
    output logic [PW-1:0]  res,
    output logic           zero,
    output logic           neg,
    output logic           inexact
);

    logic [PW-1:0] shifted;
    logic [PW-1:0] lowmask;
    logic [PW-1:0] halfmask;
    logic          rbit;
    logic          sticky;
    logic          bump;

    // Shift, derive guard and sticky bits from masks, round and flag.
    always_comb begin
        shifted  = $signed(prod) >>> dot;
        lowmask  = (PW'(1) << dot) - PW'(1);
        halfmask = lowmask ^ (lowmask >> 1);
        rbit     = |(prod & halfmask);
        sticky   = |(prod & (lowmask >> 1));
        bump     = rbit & (sticky | shifted[0]);
        res      = shifted + PW'(bump);
        zero     = (res == '0);
        neg      = res[PW-1];
        inexact  = |(prod & lowmask);
    end

endmodule

// File: rtl/fxm_lane.sv
// One lane of the multiplier: operand register, product register, rounding
// and flag register, plus an extra output stage when LAT is 4.
// Assumes: data registers advance every cycle; validity is tracked outside.
module fxm_lane #(
    parameter int W   = 16,
    parameter int SHW = 4,
    parameter int LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [SHW-1:0]   dot,
    output logic [2*W-1:0]   res,
    output logic             zero,
    output logic             neg,
    output logic             inexact
);

    localparam int PW = 2 * W;

    logic [W-1:0]   a_q, b_q;
    logic [SHW-1:0] dot_q, dot_qq;
    logic [PW-1:0]  prod_q;
    logic [PW-1:0]  rnd_res;
    logic           rnd_zero, rnd_neg, rnd_inexact;
    logic [PW-1:0]  res_q;
    logic           zero_q, neg_q, inexact_q;

    // Stage 1: capture operands and the clamped fraction count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            dot_q <= '0;
        end else begin
            a_q   <= a;
            b_q   <= b;
            dot_q <= dot;
        end
    end

    // Stage 2: full signed product, fraction count carried alongside.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            dot_qq <= '0;
        end else begin
            prod_q <= PW'($signed(a_q) * $signed(b_q));
            dot_qq <= dot_q;
        end
    end

    fxm_round #(.PW(PW), .SHW(SHW)) u_round (
        .prod    (prod_q),
        .dot     (dot_qq),
        .res     (rnd_res),
        .zero    (rnd_zero),
        .neg     (rnd_neg),
        .inexact (rnd_inexact)
    );

    // Stage 3: register the rounded result and its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            zero_q    <= 1'b0;
            neg_q     <= 1'b0;
            inexact_q <= 1'b0;
        end else begin
            res_q     <= rnd_res;
            zero_q    <= rnd_zero;
            neg_q     <= rnd_neg;
            inexact_q <= rnd_inexact;
        end
    end

    generate
        if (LAT > 3) begin : g_extra
            logic [PW-1:0] res_x;
            logic          zero_x, neg_x, inexact_x;

            // Stage 4: extra output register for wide operand sizes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_x     <= '0;
                    zero_x    <= 1'b0;
                    neg_x     <= 1'b0;
                    inexact_x <= 1'b0;
                end else begin
                    res_x     <= res_q;
                    zero_x    <= zero_q;
                    neg_x     <= neg_q;
                    inexact_x <= inexact_q;
                end
            end
            assign res     = res_x;
            assign zero    = zero_x;
            assign neg     = neg_x;
            assign inexact = inexact_x;
        end else begin : g_direct
            assign res     = res_q;
            assign zero    = zero_q;
            assign neg     = neg_q;
            assign inexact = inexact_q;
        end
    endgenerate

endmodule

// File: rtl/fxm_vpipe.sv
// Valid-flag shift register matching the lane datapath depth.
// Assumes: DEPTH is at least 2; no stall, one slot per cycle.
module fxm_vpipe #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin,
    output logic vout
);

    logic [DEPTH-1:0] sr;

    // Shift the valid flag one stage per cycle, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[DEPTH-2:0], vin};
    end

    assign vout = sr[DEPTH-1];

endmodule

// File: rtl/fxmul_round_wide.sv
// Top of the rounding widening fixed-point multiplier. Clamps the shared
// fraction count, replicates the lane datapath and tracks validity.
// Assumes: all lanes share one fraction count; no back-pressure.
module fxmul_round_wide #(
    parameter int W     = 16,
    parameter int LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES*W-1:0]     in_a,
    input  logic [LANES*W-1:0]     in_b,
    input  logic [$clog2(W):0]     in_dot,
    output logic                   out_valid,
    output logic [LANES*2*W-1:0]   out_res,
    output logic [LANES-1:0]       out_zero,
    output logic [LANES-1:0]       out_neg,
    output logic [LANES-1:0]       out_inexact,
    output logic [LANES-1:0]       out_carry,
    output logic [LANES-1:0]       out_ovf
);

    localparam int SHW  = $clog2(W);
    localparam int DOTW = SHW + 1;
    localparam int PW   = 2 * W;
    localparam int LAT  = fxm_pkg::fxm_latency(W);

    logic [SHW-1:0] dot_c;

    // Saturate out-of-range fraction counts to W-1.
    always_comb begin
        if (in_dot > DOTW'(W - 1)) dot_c = SHW'(W - 1);
        else                       dot_c = in_dot[SHW-1:0];
    end

    fxm_vpipe #(.DEPTH(LAT)) u_vpipe (
        .clk   (clk),
        .rst_n (rst_n),
        .vin   (in_valid),
        .vout  (out_valid)
    );

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            fxm_lane #(.W(W), .SHW(SHW), .LAT(LAT)) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .a       (in_a[gi*W +: W]),
                .b       (in_b[gi*W +: W]),
                .dot     (dot_c),
                .res     (out_res[gi*PW +: PW]),
                .zero    (out_zero[gi]),
                .neg     (out_neg[gi]),
                .inexact (out_inexact[gi])
            );
        end
    endgenerate

    assign out_carry = '0;
    assign out_ovf   = '0;

endmodule

// File: rtl/fxm_checker.sv
// Property checker for fxmul_round_wide, attached by bind.
// Assumes: same parameters as the bound instance.
module fxm_checker #(
    parameter int W     = 16,
    parameter int LANES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [$clog2(W):0]   in_dot,
    input logic                 out_valid,
    input logic [LANES*2*W-1:0] out_res,
    input logic [LANES-1:0]     out_zero,
    input logic [LANES-1:0]     out_neg,
    input logic [LANES-1:0]     out_inexact
);

    localparam int PW  = 2 * W;
    localparam int LAT = fxm_pkg::fxm_latency(W);

    int unsigned since_rst;

    // Count edges since reset release, saturating at the latency.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= 0;
        else if (since_rst < LAT)   since_rst <= since_rst + 1;
    end

    assert_reset_idle_R11: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    assert_fixed_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= LAT) |-> (out_valid == $past(in_valid, LAT)));

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_chk
            assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (out_zero[gi] == (out_res[gi*PW +: PW] == '0)));

            assert_neg_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (out_neg[gi] == out_res[gi*PW + PW - 1]));

            assert_exact_at_zero_dot_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst >= LAT && out_valid && $past(in_dot, LAT) == '0) |-> !out_inexact[gi]);
        end
    endgenerate

endmodule

bind fxmul_round_wide fxm_checker #(.W(W), .LANES(LANES)) u_fxm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_dot      (in_dot),
    .out_valid   (out_valid),
    .out_res     (out_res),
    .out_zero    (out_zero),
    .out_neg     (out_neg),
    .out_inexact (out_inexact)
);

// File: tb/tb_fxmul_round_wide.sv
`timescale 1ns/1ps
// Bench for fxmul_round_wide: a 16-bit two-lane copy and a 40-bit one-lane copy,
// driven by fixed-seed random stimulus plus directed corners, checked against
// a reference model using division-style remainder rounding.
module tb_fxmul_round_wide;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    // 16-bit, two lanes, latency 3
    logic        v16_i = 1'b0;
    logic [31:0] a16 = '0, b16 = '0;
    logic [4:0]  d16 = '0;
    logic        v16_o;
    logic [63:0] r16;
    logic [1:0]  z16, n16, x16, c16, o16;

    // 40-bit, one lane, latency 4
    logic        vw_i = 1'b0;
    logic [39:0] aw = '0, bw = '0;
    logic [6:0]  dw = '0;
    logic        vw_o;
    logic [79:0] rw;
    logic        zw, nw, xw, cw, ow;

    fxmul_round_wide #(.W(16), .LANES(2)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(v16_i), .in_a(a16), .in_b(b16),
        .in_dot(d16), .out_valid(v16_o), .out_res(r16), .out_zero(z16),
        .out_neg(n16), .out_inexact(x16), .out_carry(c16), .out_ovf(o16));

    fxmul_round_wide #(.W(40), .LANES(1)) dut_w40 (
        .clk(clk), .rst_n(rst_n), .in_valid(vw_i), .in_a(aw), .in_b(bw),
        .in_dot(dw), .out_valid(vw_o), .out_res(rw), .out_zero(zw),
        .out_neg(nw), .out_inexact(xw), .out_carry(cw), .out_ovf(ow));

    typedef struct packed {
        logic [63:0] res;
        logic [1:0]  z, n, x;
        logic [31:0] tag;
        logic [31:0] cyc;
    } e16_t;

    typedef struct packed {
        logic [79:0] res;
        logic        z, n, x;
        logic [31:0] tag;
        logic [31:0] cyc;
    } ew_t;

    e16_t q16[$];
    ew_t  qw[$];

    // Reference: {tie, inexact, neg, zero, result[127:0]}
    function automatic logic [131:0] model(input longint a, input longint b,
                                           input int dot, input int w);
        logic signed [127:0] pa, pb, p, q, rem, half;
        int d;
        logic tie;
        pa = a;
        pb = b;
        p  = pa * pb;
        d  = (dot > w - 1) ? w - 1 : dot;
        q  = p >>> d;
        rem = p - (q <<< d);
        half = (d == 0) ? 128'sd0 : (128'sd1 <<< (d - 1));
        tie = (d > 0) && (rem == half);
        if (d > 0 && (rem > half || (tie && q[0]))) q = q + 1;
        return {tie, rem != 0, q < 0, q == 0, q};
    endfunction

    // Which requirement a vector mainly targets: R4 clamp, R3 zero dot, R2 tie, else R1.
    function automatic int tag_of(input logic [131:0] m, input int dot, input int w);
        if (dot > w - 1) return 4;
        if (dot == 0)    return 3;
        if (m[131])      return 2;
        return 1;
    endfunction

    task automatic step(input logic [15:0] x0, input logic [15:0] y0,
                        input logic [15:0] x1, input logic [15:0] y1,
                        input logic [4:0] dd16, input bit vv16,
                        input logic [39:0] xa, input logic [39:0] ya,
                        input logic [6:0] ddw, input bit vvw);
        logic [131:0] m;
        e16_t e;
        ew_t  f;
        int   t;
        @(negedge clk);
        a16 = {x1, x0}; b16 = {y1, y0}; d16 = dd16; v16_i = vv16;
        aw = xa; bw = ya; dw = ddw; vw_i = vvw;
        if (vv16) begin
            e = '0;
            e.cyc = cyc;
            e.tag = 1;
            for (int i = 0; i < 2; i++) begin
                m = model(longint'($signed(i == 0 ? x0 : x1)),
                          longint'($signed(i == 0 ? y0 : y1)), int'(dd16), 16);
                e.res[i*32 +: 32] = m[31:0];
                e.z[i] = m[128]; e.n[i] = m[129]; e.x[i] = m[130];
                t = tag_of(m, int'(dd16), 16);
                if (t > 1) e.tag = t;
            end
            q16.push_back(e);
        end
        if (vvw) begin
            f = '0;
            f.cyc = cyc;
            m = model(longint'($signed(xa)), longint'($signed(ya)), int'(ddw), 40);
            f.res = m[79:0];
            f.z = m[128]; f.n = m[129]; f.x = m[130];
            f.tag = tag_of(m, int'(ddw), 40);
            qw.push_back(f);
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Output checks for the 16-bit copy, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n && v16_o) begin
            e16_t e;
            if (q16.size() == 0) begin
                chk(1'b0, "R9 unexpected valid", 1, 0);
            end else begin
                e = q16.pop_front();
                chk((cyc - int'(e.cyc)) == 3, "R9 latency16", cyc - int'(e.cyc), 3);
                for (int i = 0; i < 2; i++) begin
                    // R1 value / R2 tie / R3 exact / R4 clamp; lane slicing is R10
                    chk(r16[i*32 +: 32] == e.res[i*32 +: 32],
                        $sformatf("R%0d result16 lane%0d (R10)", e.tag, i),
                        r16[i*32 +: 32], e.res[i*32 +: 32]);
                    chk(z16[i] == e.z[i], "R5 zero16", z16[i], e.z[i]);
                    chk(n16[i] == e.n[i], "R6 neg16", n16[i], e.n[i]);
                    chk(x16[i] == e.x[i], "R7 inexact16", x16[i], e.x[i]);
                    chk(c16[i] == 1'b0 && o16[i] == 1'b0, "R8 carry/ovf16",
                        {c16[i], o16[i]}, 0);
                end
            end
        end
    end

    // Output checks for the 40-bit copy.
    always @(negedge clk) begin
        if (rst_n && vw_o) begin
            ew_t f;
            if (qw.size() == 0) begin
                chk(1'b0, "R9 unexpected valid w40", 1, 0);
            end else begin
                f = qw.pop_front();
                chk((cyc - int'(f.cyc)) == 4, "R9 latency40", cyc - int'(f.cyc), 4);
                chk(rw == f.res, $sformatf("R%0d result40", f.tag), rw, f.res);
                chk(zw == f.z, "R5 zero40", zw, f.z);
                chk(nw == f.n, "R6 neg40", nw, f.n);
                chk(xw == f.x, "R7 inexact40", xw, f.x);
                chk(cw == 1'b0 && ow == 1'b0, "R8 carry/ovf40", {cw, ow}, 0);
            end
        end
    end

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2_000_000;
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'h5eed_0042);
        void'($urandom(32'h5eed_0042));
        // R11: reset state
        repeat (4) @(negedge clk);
        chk(v16_o == 1'b0 && vw_o == 1'b0, "R11 valid in reset", {v16_o, vw_o}, 0);
        chk(r16 == '0 && rw == '0, "R11 result in reset", r16 | 64'(rw), 0);
        rst_n = 1'b1;

        // R2: ties to even, positive then negative, different per lane (R10)
        step(16'd1, 16'd1, 16'd3, 16'd1, 5'd1, 1, 40'd5, 40'd1, 7'd1, 1);
        step(-16'sd1, 16'd1, -16'sd3, 16'd1, 5'd1, 1,
             -40'sd5, 40'd1, 7'd1, 1);
        step(16'd5, 16'd1, 16'd7, 16'd1, 5'd2, 1,
             40'd6, 40'd1, 7'd2, 1);
        // R3: exact product, most negative operand squared
        step(16'h8000, 16'h8000, 16'h7fff, 16'h8000, 5'd0, 1,
             40'h80_0000_0000, 40'h80_0000_0000, 7'd0, 1);
        // R4: out-of-range fraction counts clamp to W-1
        step(16'h4000, 16'h4000, 16'd123, -16'sd77, 5'd31, 1,
             40'h40_0000_0000, 40'h12_3456_789a, 7'd127, 1);
        step(16'h7fff, 16'h7fff, 16'h8000, 16'h7fff, 5'd16, 1,
             40'h7f_ffff_ffff, 40'h7f_ffff_ffff, 7'd40, 1);
        // R5/R6: zero and negative results
        step(16'd0, 16'd5, 16'd5, -16'sd3, 5'd4, 1,
             40'd0, 40'd9, 7'd3, 1);
        step(16'd1, 16'd1, -16'sd1, 16'd1, 5'd4, 1,
             -40'sd1, 40'd1, 7'd20, 1);
        // R9: idle gap then back-to-back issue
        step(16'd0, 16'd0, 16'd0, 16'd0, 5'd0, 0, 40'd0, 40'd0, 7'd0, 0);

        // Random stream with valid gaps, mostly in-range fraction counts.
        for (int k = 0; k < 3000; k++) begin
            logic [4:0] rd16;
            logic [6:0] rdw;
            rd16 = ($urandom % 8 == 0) ? 5'(16 + $urandom % 16) : 5'($urandom % 16);
            rdw  = ($urandom % 8 == 0) ? 7'(40 + $urandom % 88) : 7'($urandom % 40);
            step(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                 rd16, ($urandom % 8) != 0,
                 40'({$urandom, $urandom}), 40'({$urandom, $urandom}),
                 rdw, ($urandom % 8) != 0);
        end

        step(16'd0, 16'd0, 16'd0, 16'd0, 5'd0, 0, 40'd0, 40'd0, 7'd0, 0);
        repeat (8) @(negedge clk);
        // R9: every issued operation must have come out
        chk(q16.size() == 0, "R9 drained16", q16.size(), 0);
        chk(qw.size() == 0, "R9 drained40", qw.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule